// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the per-channel control front end of a descriptor-driven DMA controller. A 32-bit register bus reaches a bank of channel windows, each 0x2000 bytes wide. The unit decodes which channel and which register an access targets. It keeps each channel's pointer, configuration, command, interrupt mask and stream-command registers, and it composes a status word from live state that the descriptor engine reports.

Each channel turns its raw interrupt causes, its mask and software acknowledges into a single level-sensitive interrupt line. Writes to the stream-command and command registers are commands as well as stores. They become one-cycle load-data, load-context, start and continue strobes for the descriptor engine, which sits outside this unit. Every bus request is answered one cycle later by exactly one of two outputs: an acknowledge, carrying read data for reads, or an error. The bus has no back-pressure, so a request is always taken in the cycle it is presented. The engine-side inputs are plain levels that are sampled every cycle.

Top module: `dmach_regs`

## Requirements
- R1: The channel index is (bus_addr − BASE) >> 13 and the register offset is the low 13 bits of (bus_addr − BASE). A write changes only the addressed channel.
- R2: These offsets read back the last value written: 0x00 data pointer, 0x58 saved descriptor, 0x5C saved buffer, 0x60 group, 0x7C group-down, 0x80 command and 0x84 config (all 32 bits), and 0x8C interrupt mask (low CAUSE_W bits). Offset 0x9C keeps bits [9:0] of a write and reads zeros above them.
- R3: Offset 0x88 is read-only. It returns the engine state in bits [2:0] (0 reset, 2 stopped, 4 running), the end-of-list flag in bit 5 and the stream-command source in bits [8+SRC_W-1:8], with zeros elsewhere.
- R4: Writing offset 0x90 clears each raw cause bit that is set in the written value. Offset 0x90 always reads zero, and writes to offset 0x94 (raw causes) are ignored.
- R5: Offset 0x98 reads raw & mask. A channel's irq is high exactly when raw & mask is nonzero, and it follows a cause, mask write or acknowledge on the next clock edge.
- R6: A cause bit that is asserted in the same cycle as an acknowledge of that bit stays set.
- R7: A stream-command write with any bit of 0x140 set gives a one-cycle ld_data pulse. If bit 0x20 is also set, it gives a ch_start pulse too. Bit 0x20 on its own does nothing.
- R8: A stream-command write with bit 0x200 set gives a one-cycle ld_ctx pulse together with ch_start.
- R9: A write to offset 0x80 gives a one-cycle ch_cont pulse only when config bit 0 (enable) is 1, config bit 1 (stop) is 0, a client is attached, the engine state is running (4) and the current descriptor's end-of-list flag is set.
- R10: An access that is not a word (bus_size ≠ 2), is not word-aligned, or targets a channel index of NCH or above is answered with bus_err and changes no register.
- R11: Every legal request is answered with bus_ack one cycle later, with read data on bus_rdata. An offset that has no register reads zero, and writes to it are ignored.
- R12: After reset, every register reads zero, every irq line is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_addr | input | ADDR_W (32) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Legal access completed |
| bus_err | output | 1 | Illegal access rejected |
| eng_state | input | NCH*3 (12) | Per-channel engine state code |
| eng_eol | input | NCH (4) | Per-channel end-of-list reached flag |
| eng_src | input | NCH*SRC_W (8) | Per-channel stream-command source |
| eng_client | input | NCH (4) | Client attached to the channel |
| eng_deol | input | NCH (4) | Current data descriptor has end-of-list set |
| eng_cause | input | NCH*CAUSE_W (16) | Raw interrupt cause pulses |
| irq | output | NCH (4) | Interrupt line per channel |
| ld_data | output | NCH (4) | Load data-descriptor strobe |
| ld_ctx | output | NCH (4) | Load context strobe |
| ch_start | output | NCH (4) | Start channel strobe |
| ch_cont | output | NCH (4) | Continue strobe |

## Verification
The bench aims at the acknowledge path. It acknowledges a bit while the same cause fires, which a design that lets the clear win would lose. It also checks that the acknowledge register reads zero and that raw causes cannot be written. It walks every condition of the continue gate one at a time, so a design that drops any term of the gate would strobe when it should not. It sends stream commands with the burst bit alone, with load-data alone, with both, and with load-context, which catches a design that starts a channel without a load. It also sends byte, misaligned and out-of-range accesses and then reads back the registers they targeted, so a design that writes on an error would show it.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int OFF_W = 13;

  localparam logic [OFF_W-1:0] OFF_DPTR  = 13'h000;
  localparam logic [OFF_W-1:0] OFF_SDESC = 13'h058;
  localparam logic [OFF_W-1:0] OFF_SBUF  = 13'h05C;
  localparam logic [OFF_W-1:0] OFF_GRP   = 13'h060;
  localparam logic [OFF_W-1:0] OFF_GDOWN = 13'h07C;
  localparam logic [OFF_W-1:0] OFF_CMD   = 13'h080;
  localparam logic [OFF_W-1:0] OFF_CFG   = 13'h084;
  localparam logic [OFF_W-1:0] OFF_STAT  = 13'h088;
  localparam logic [OFF_W-1:0] OFF_IMASK = 13'h08C;
  localparam logic [OFF_W-1:0] OFF_IACK  = 13'h090;
  localparam logic [OFF_W-1:0] OFF_IRAW  = 13'h094;
  localparam logic [OFF_W-1:0] OFF_IMSKD = 13'h098;
  localparam logic [OFF_W-1:0] OFF_SCMD  = 13'h09C;

  typedef enum logic [3:0] {
    RS_NONE, RS_DPTR, RS_SDESC, RS_SBUF, RS_GRP, RS_GDOWN, RS_CMD,
    RS_CFG, RS_STAT, RS_IMASK, RS_IACK, RS_IRAW, RS_IMSKD, RS_SCMD
  } reg_sel_e;

  localparam logic [2:0] ST_RUNNING = 3'd4;

  localparam int SC_W = 10;
  localparam logic [SC_W-1:0] SC_LOAD_DATA = 10'h140;
  localparam logic [SC_W-1:0] SC_BURST     = 10'h020;
  localparam logic [SC_W-1:0] SC_LOAD_CTX  = 10'h200;

  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic              req,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic [NCH-1:0]    ch_sel,
  output logic [CH_W-1:0]   ch_idx,
  output reg_sel_e          rsel
);

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx_full;
  logic [OFF_W-1:0]  off;
  logic              legal;

  assign rel      = addr - BASE;
  assign idx_full = rel[ADDR_W-1:OFF_W];
  assign off      = rel[OFF_W-1:0];
  assign legal    = (size == SZ_WORD) && (off[1:0] == 2'b00) &&
                    (idx_full < IDX_W'(NCH));
  assign acc_ok   = req && legal;
  assign acc_bad  = req && !legal;
  assign ch_idx   = idx_full[CH_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign ch_sel[g] = acc_ok && (idx_full == IDX_W'(g));
  end

  always_comb begin
    unique case (off)
      OFF_DPTR:  rsel = RS_DPTR;
      OFF_SDESC: rsel = RS_SDESC;
      OFF_SBUF:  rsel = RS_SBUF;
      OFF_GRP:   rsel = RS_GRP;
      OFF_GDOWN: rsel = RS_GDOWN;
      OFF_CMD:   rsel = RS_CMD;
      OFF_CFG:   rsel = RS_CFG;
      OFF_STAT:  rsel = RS_STAT;
      OFF_IMASK: rsel = RS_IMASK;
      OFF_IACK:  rsel = RS_IACK;
      OFF_IRAW:  rsel = RS_IRAW;
      OFF_IMSKD: rsel = RS_IMSKD;
      OFF_SCMD:  rsel = RS_SCMD;
      default:   rsel = RS_NONE;
    endcase
  end

endmodule

// File: rtl/dmach_irq.sv
module dmach_irq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          ack_we,
  input  logic [CW-1:0] wbits,
  input  logic [CW-1:0] cause,
  output logic [CW-1:0] raw,
  output logic [CW-1:0] mask,
  output logic          irq
);

  logic [CW-1:0] raw_q, mask_q, kept;

  // acknowledge removes bits first; a cause in the same cycle re-sets them
  assign kept = ack_we ? (raw_q & ~wbits) : raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= kept | cause;
      if (mask_we) mask_q <= wbits;
    end
  end

  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);

endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
  import dmach_pkg::*;
#(
  parameter int CW    = 4,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  reg_sel_e         rsel,
  input  logic [31:0]      wdata,
  input  logic [2:0]       st,
  input  logic             eol,
  input  logic [SRC_W-1:0] src,
  input  logic             client,
  input  logic             deol,
  input  logic [CW-1:0]    cause,
  output logic [31:0]      rd_val,
  output logic             irq,
  output logic             ld_data,
  output logic             ld_ctx,
  output logic             start,
  output logic             cont,
  output logic [CW-1:0]    raw,
  output logic [CW-1:0]    mask
);

  logic [31:0]     dptr_q, sdesc_q, sbuf_q, grp_q, gdown_q, cmd_q, cfg_q;
  logic [SC_W-1:0] scmd_q;
  logic            wr, scmd_wr, cmd_wr;
  logic            ld_d_n, ld_c_n, start_n, cont_n;
  logic            en_ok;
  logic [31:0]     stat;
  logic [SC_W-1:0] sc;

  assign wr      = sel && we;
  assign scmd_wr = wr && (rsel == RS_SCMD);
  assign cmd_wr  = wr && (rsel == RS_CMD);
  assign sc      = wdata[SC_W-1:0];

  assign en_ok   = cfg_q[0] && client && !cfg_q[1] && (st == ST_RUNNING) && deol;
  assign ld_d_n  = scmd_wr && |(sc & SC_LOAD_DATA);
  assign ld_c_n  = scmd_wr && |(sc & SC_LOAD_CTX);
  assign start_n = (ld_d_n && |(sc & SC_BURST)) || ld_c_n;
  assign cont_n  = cmd_wr && en_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr_q  <= '0;
      sdesc_q <= '0;
      sbuf_q  <= '0;
      grp_q   <= '0;
      gdown_q <= '0;
      cmd_q   <= '0;
      cfg_q   <= '0;
      scmd_q  <= '0;
    end else if (wr) begin
      unique case (rsel)
        RS_DPTR:  dptr_q  <= wdata;
        RS_SDESC: sdesc_q <= wdata;
        RS_SBUF:  sbuf_q  <= wdata;
        RS_GRP:   grp_q   <= wdata;
        RS_GDOWN: gdown_q <= wdata;
        RS_CMD:   cmd_q   <= wdata;
        RS_CFG:   cfg_q   <= wdata;
        RS_SCMD:  scmd_q  <= sc;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_data <= 1'b0;
      ld_ctx  <= 1'b0;
      start   <= 1'b0;
      cont    <= 1'b0;
    end else begin
      ld_data <= ld_d_n;
      ld_ctx  <= ld_c_n;
      start   <= start_n;
      cont    <= cont_n;
    end
  end

  dmach_irq #(.CW(CW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (wr && (rsel == RS_IMASK)),
    .ack_we  (wr && (rsel == RS_IACK)),
    .wbits   (wdata[CW-1:0]),
    .cause   (cause),
    .raw     (raw),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    stat             = '0;
    stat[2:0]        = st;
    stat[5]          = eol;
    stat[8 +: SRC_W] = src;
  end

  always_comb begin
    unique case (rsel)
      RS_DPTR:  rd_val = dptr_q;
      RS_SDESC: rd_val = sdesc_q;
      RS_SBUF:  rd_val = sbuf_q;
      RS_GRP:   rd_val = grp_q;
      RS_GDOWN: rd_val = gdown_q;
      RS_CMD:   rd_val = cmd_q;
      RS_CFG:   rd_val = cfg_q;
      RS_STAT:  rd_val = stat;
      RS_IMASK: rd_val = 32'(mask);
      RS_IRAW:  rd_val = 32'(raw);
      RS_IMSKD: rd_val = 32'(raw & mask);
      RS_SCMD:  rd_val = 32'(scmd_q);
      default:  rd_val = '0;
    endcase
  end

endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ADDR_W  = 32,
  parameter int CAUSE_W = 4,
  parameter int SRC_W   = 2,
  parameter logic [ADDR_W-1:0] BASE = 32'hB000_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic [1:0]               bus_size,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_ack,
  output logic                     bus_err,
  input  logic [NCH*3-1:0]         eng_state,
  input  logic [NCH-1:0]           eng_eol,
  input  logic [NCH*SRC_W-1:0]     eng_src,
  input  logic [NCH-1:0]           eng_client,
  input  logic [NCH-1:0]           eng_deol,
  input  logic [NCH*CAUSE_W-1:0]   eng_cause,
  output logic [NCH-1:0]           irq,
  output logic [NCH-1:0]           ld_data,
  output logic [NCH-1:0]           ld_ctx,
  output logic [NCH-1:0]           ch_start,
  output logic [NCH-1:0]           ch_cont
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                     acc_ok, acc_bad;
  logic [NCH-1:0]           ch_sel;
  logic [CH_W-1:0]          ch_idx;
  reg_sel_e                 rsel;
  logic [31:0]              rd_arr [NCH];
  logic [NCH*CAUSE_W-1:0]   raw_all, mask_all;

  dmach_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .req     (bus_req),
    .size    (bus_size),
    .addr    (bus_addr),
    .acc_ok  (acc_ok),
    .acc_bad (acc_bad),
    .ch_sel  (ch_sel),
    .ch_idx  (ch_idx),
    .rsel    (rsel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmach_chan #(.CW(CAUSE_W), .SRC_W(SRC_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ch_sel[c]),
      .we      (bus_we),
      .rsel    (rsel),
      .wdata   (bus_wdata),
      .st      (eng_state[c*3 +: 3]),
      .eol     (eng_eol[c]),
      .src     (eng_src[c*SRC_W +: SRC_W]),
      .client  (eng_client[c]),
      .deol    (eng_deol[c]),
      .cause   (eng_cause[c*CAUSE_W +: CAUSE_W]),
      .rd_val  (rd_arr[c]),
      .irq     (irq[c]),
      .ld_data (ld_data[c]),
      .ld_ctx  (ld_ctx[c]),
      .start   (ch_start[c]),
      .cont    (ch_cont[c]),
      .raw     (raw_all[c*CAUSE_W +: CAUSE_W]),
      .mask    (mask_all[c*CAUSE_W +: CAUSE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      bus_ack   <= acc_ok;
      bus_err   <= acc_bad;
      bus_rdata <= (acc_ok && !bus_we) ? rd_arr[ch_idx] : '0;
    end
  end

endmodule

// File: rtl/dmach_regs_chk.sv
module dmach_regs_chk #(
  parameter int NCH = 4,
  parameter int CW  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_we,
  input logic               bus_ack,
  input logic               bus_err,
  input logic [NCH*3-1:0]   eng_state,
  input logic [NCH-1:0]     eng_client,
  input logic [NCH-1:0]     eng_deol,
  input logic [NCH*CW-1:0]  eng_cause,
  input logic [NCH-1:0]     ld_data,
  input logic [NCH-1:0]     ld_ctx,
  input logic [NCH-1:0]     ch_start,
  input logic [NCH-1:0]     ch_cont,
  input logic [NCH*CW-1:0]  raw_all,
  input logic [NCH*CW-1:0]  mask_all
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R8
  ctx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctx & ~ch_start) == '0);

  // R7
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start & ~(ld_ctx | ld_data)) == '0);

  // R10
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));

  // R11
  resp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (bus_ack || bus_err)) |-> $past(bus_req));

  // R6
  cause_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(eng_cause) & ~raw_all) == '0));

  // R4
  raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((raw_all & ~$past(raw_all) & ~$past(eng_cause)) == '0));

  // R10
  err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && bus_err) |-> $stable(mask_all));

  // R12
  strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ld_data | ld_ctx | ch_cont)) |-> bus_ack);

  for (genvar i = 0; i < NCH; i++) begin : g_cont
    // R9
    cont_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ch_cont[i]) |->
        $past(eng_client[i] && eng_deol[i] && (eng_state[i*3 +: 3] == 3'd4)
              && bus_req && bus_we));
  end

endmodule

bind dmach_regs dmach_regs_chk #(.NCH(NCH), .CW(CAUSE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_ack    (bus_ack),
  .bus_err    (bus_err),
  .eng_state  (eng_state),
  .eng_client (eng_client),
  .eng_deol   (eng_deol),
  .eng_cause  (eng_cause),
  .ld_data    (ld_data),
  .ld_ctx     (ld_ctx),
  .ch_start   (ch_start),
  .ch_cont    (ch_cont),
  .raw_all    (raw_all),
  .mask_all   (mask_all)
);

// File: tb/dmach_regs_tb.sv
`timescale 1ns/1ps
module dmach_regs_tb;

  localparam int CLK_PER = 10;
  localparam int NCH = 4;
  localparam int CW  = 4;
  localparam int SW  = 2;
  localparam logic [31:0] BASE = 32'hB000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [1:0] bus_size = 2'd2;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_ack, bus_err;
  logic [NCH*3-1:0]  eng_state = '0;
  logic [NCH-1:0]    eng_eol = '0, eng_client = '0, eng_deol = '0;
  logic [NCH*SW-1:0] eng_src = '0;
  logic [NCH*CW-1:0] eng_cause = '0, pend_cause = '0;
  logic [NCH-1:0]    irq, ld_data, ld_ctx, ch_start, ch_cont;
  logic [NCH-1:0]    c_ld, c_ctx, c_st, c_ct;

  int checks = 0, bad = 0;
  bit done = 0;

  typedef struct { bit rd; bit err; logic [31:0] data; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PER/2) clk = ~clk;

  dmach_regs #(.NCH(NCH), .CAUSE_W(CW), .SRC_W(SW), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .eng_state(eng_state), .eng_eol(eng_eol), .eng_src(eng_src),
    .eng_client(eng_client), .eng_deol(eng_deol), .eng_cause(eng_cause),
    .irq(irq), .ld_data(ld_data), .ld_ctx(ld_ctx), .ch_start(ch_start),
    .ch_cont(ch_cont)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && (bus_ack || bus_err)) begin
      if (sb.size() == 0) begin
        chk(0, "R11 unexpected response", {30'b0, bus_err, bus_ack}, 32'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(bus_err == it.err, {it.tag, " err"}, 32'(bus_err), 32'(it.err));
        if (it.rd && !it.err)
          chk(bus_rdata == it.data, it.tag, bus_rdata, it.data);
      end
    end
  end

  function automatic logic [31:0] ad(input int ch, input logic [12:0] off);
    return BASE + 32'(ch) * 32'h2000 + 32'(off);
  endfunction

  task automatic acc(input bit we, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] wd, input bit e, input logic [31:0] ex,
                     input string tag);
    item_t it;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    eng_cause = pend_cause;
    it.rd = !we; it.err = e; it.data = ex; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    c_ld = ld_data; c_ctx = ld_ctx; c_st = ch_start; c_ct = ch_cont;
    bus_req = 0; bus_we = 0; bus_size = 2'd2;
    eng_cause = '0; pend_cause = '0;
  endtask

  task automatic wr(input int ch, input logic [12:0] off, input logic [31:0] d);
    acc(1, 2'd2, ad(ch, off), d, 0, 0, "R11 write ack");
  endtask

  task automatic rd(input int ch, input logic [12:0] off, input logic [31:0] ex,
                    input string tag);
    acc(0, 2'd2, ad(ch, off), 0, 0, ex, tag);
  endtask

  task automatic strobes(input logic [NCH-1:0] eld, ectx, est, ect,
                         input string tag);
    chk({c_ld, c_ctx, c_st, c_ct} == {eld, ectx, est, ect}, tag,
        32'({c_ld, c_ctx, c_st, c_ct}), 32'({eld, ectx, est, ect}));
  endtask

  task automatic cause(input int ch, input logic [CW-1:0] v);
    @(negedge clk);
    eng_cause[ch*CW +: CW] = v;
    @(negedge clk);
    eng_cause = '0;
  endtask

  initial begin
    #(CLK_PER*200000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk(irq == 0 && ld_data == 0 && ch_start == 0 && ch_cont == 0,
        "R12 outputs after reset", 32'(irq), 0);
    rd(0, 13'h084, 0, "R12 cfg reset");
    rd(0, 13'h088, 0, "R12 status reset");
    rd(3, 13'h094, 0, "R12 raw reset");

    // R1/R2 read back, channel isolation
    wr(1, 13'h060, 32'hDEAD_BEEF);
    rd(1, 13'h060, 32'hDEAD_BEEF, "R2 group ch1");
    rd(0, 13'h060, 0, "R1 group ch0 untouched");
    wr(2, 13'h058, 32'h1234_5670);
    rd(2, 13'h058, 32'h1234_5670, "R2 saved desc ch2");
    wr(3, 13'h07C, 32'hCAFE_0010);
    wr(3, 13'h05C, 32'h0000_ABC0);
    wr(3, 13'h000, 32'h5555_AAAA);
    rd(3, 13'h07C, 32'hCAFE_0010, "R2 group-down ch3");
    rd(3, 13'h05C, 32'h0000_ABC0, "R2 saved buf ch3");
    rd(3, 13'h000, 32'h5555_AAAA, "R2 data ptr ch3");
    wr(2, 13'h080, 32'hA5);
    strobes(0, 0, 0, 0, "R9 no continue without client");
    rd(2, 13'h080, 32'hA5, "R2 command ch2");

    // R3 status composition
    eng_state[8:6] = 3'd4; eng_eol[2] = 1; eng_src[5:4] = 2'd2;
    rd(2, 13'h088, 32'h224, "R3 status ch2");
    wr(2, 13'h088, 32'hFFFF_FFFF);
    rd(2, 13'h088, 32'h224, "R3 status write ignored");

    // R5 mask / irq
    wr(0, 13'h08C, 32'h5);
    cause(0, 4'h4);
    chk(irq == 4'b0001, "R5 irq on masked cause", 32'(irq), 1);
    rd(0, 13'h094, 32'h4, "R5 raw");
    rd(0, 13'h098, 32'h4, "R5 masked");
    cause(0, 4'h2);
    rd(0, 13'h094, 32'h6, "R5 raw accum");
    rd(0, 13'h098, 32'h4, "R5 masked filters");
    wr(0, 13'h08C, 32'h0);
    chk(irq == 0, "R5 irq low when masked off", 32'(irq), 0);
    rd(0, 13'h098, 32'h0, "R5 masked zero");
    wr(0, 13'h08C, 32'h5);
    chk(irq == 4'b0001, "R5 irq back on mask", 32'(irq), 1);

    // R4 acknowledge
    wr(0, 13'h090, 32'h4);
    chk(irq == 0, "R4 irq cleared by ack", 32'(irq), 0);
    rd(0, 13'h094, 32'h2, "R4 raw after ack");
    rd(0, 13'h090, 32'h0, "R4 ack reads zero");
    wr(0, 13'h094, 32'hF);
    rd(0, 13'h094, 32'h2, "R4 raw not writable");

    // R6 cause wins over simultaneous ack
    pend_cause[3:0] = 4'h1;
    acc(1, 2'd2, ad(0, 13'h090), 32'h1, 0, 0, "R6 ack write");
    rd(0, 13'h094, 32'h3, "R6 cause kept");
    chk(irq == 4'b0001, "R6 irq", 32'(irq), 1);

    // R7 / R8 stream commands
    wr(1, 13'h09C, 32'h040);
    strobes(4'b0010, 0, 0, 0, "R7 load data only");
    wr(1, 13'h09C, 32'h160);
    strobes(4'b0010, 0, 4'b0010, 0, "R7 load data with burst");
    wr(1, 13'h09C, 32'h020);
    strobes(0, 0, 0, 0, "R7 burst alone");
    wr(1, 13'h09C, 32'h100);
    strobes(4'b0010, 0, 0, 0, "R7 other load-data bit");
    rd(1, 13'h09C, 32'h100, "R2 stream cmd readback");
    wr(3, 13'h09C, 32'h200);
    strobes(0, 4'b1000, 4'b1000, 0, "R8 load context");
    wr(3, 13'h09C, 32'hFFFF_F200);
    strobes(0, 4'b1000, 4'b1000, 0, "R8 upper bits ignored");
    rd(3, 13'h09C, 32'h200, "R2 stream cmd 10 bits");

    // R9 continue gate
    eng_client[1] = 1; eng_state[5:3] = 3'd4; eng_deol[1] = 1;
    wr(1, 13'h084, 32'h1);
    wr(1, 13'h080, 32'h1);
    strobes(0, 0, 0, 4'b0010, "R9 continue honoured");
    eng_deol[1] = 0;
    wr(1, 13'h080, 32'h1);
    strobes(0, 0, 0, 0, "R9 no eol");
    eng_deol[1] = 1;
    wr(1, 13'h084, 32'h3);
    wr(1, 13'h080, 32'h1);
    strobes(0, 0, 0, 0, "R9 stopped");
    wr(1, 13'h084, 32'h1);
    eng_client[1] = 0;
    wr(1, 13'h080, 32'h1);
    strobes(0, 0, 0, 0, "R9 no client");
    eng_client[1] = 1; eng_state[5:3] = 3'd2;
    wr(1, 13'h080, 32'h1);
    strobes(0, 0, 0, 0, "R9 not running");
    eng_state[5:3] = 3'd4;
    wr(1, 13'h084, 32'h0);
    wr(1, 13'h080, 32'h1);
    strobes(0, 0, 0, 0, "R9 disabled");

    // R10 illegal accesses
    acc(1, 2'd0, ad(0, 13'h084), 32'h1, 1, 0, "R10 byte write");
    rd(0, 13'h084, 0, "R10 cfg unchanged");
    acc(1, 2'd1, ad(0, 13'h08C), 32'h0, 1, 0, "R10 half write");
    rd(0, 13'h08C, 32'h5, "R10 mask unchanged");
    acc(0, 2'd2, ad(4, 13'h084), 0, 1, 0, "R10 channel out of range");
    acc(1, 2'd2, ad(2, 13'h059), 32'h77, 1, 0, "R10 misaligned");
    rd(2, 13'h058, 32'h1234_5670, "R10 saved desc unchanged");

    // R11 unmapped offset
    wr(1, 13'h040, 32'h1234);
    rd(1, 13'h040, 0, "R11 unmapped reads zero");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 all responses seen", 32'(sb.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule